// File: doc/BRIEF.md
# Zero-Delimited Byte-Stuffed Frame Decoder

This block sits on a byte stream in which frames are separated by 0x00 bytes and in which every other zero has been removed by consistent-overhead byte stuffing. It walks each frame one block at a time. A code byte states how many bytes the block carries. The data bytes are copied through unchanged, and a zero that was removed at encoding is put back between blocks. The restored frame leaves on a valid/ready byte stream. The last byte of the frame is marked with a last flag, and a one-bit error flag on that last byte reports a malformed frame.

The zero that may follow a block can only be placed once it is known that the frame goes on. The end of a frame is only known when the delimiter arrives. For this reason the decoder always holds back the most recent decoded byte, so that it can attach the last and error flags to that byte once the frame closes. A frame that decodes to no bytes at all still produces one output byte (0x00) with both flags set, so that the receiver always sees the frame end.

Top module: `cobs_frame_decoder`

## Requirements
- R1: The first non-zero byte of a frame, and the byte after each completed block, is a code N (1 to 255). The N-1 bytes after it leave the block unchanged and in order.
- R2: When a block with code below 255 completes and a further non-zero byte of the same frame follows, a 0x00 byte is emitted between that block's data and the following data.
- R3: After a block with code 255, no zero byte is emitted.
- R4: No zero byte is emitted after the final block of a frame, whatever its code.
- R5: An input byte 0x00 closes the frame and is never output as data. The last decoded byte carries out_last=1, and out_user=0 when every block was complete.
- R6: When the delimiter arrives while a block still expects data bytes, the final output byte of that frame carries out_user=1. out_user is 0 on every byte that does not carry out_last.
- R7: A frame that decodes to no bytes produces exactly one output byte 0x00 with out_last=1 and out_user=1.
- R8: A 0x00 byte arriving outside a frame (leading or repeated delimiters) produces no output.
- R9: While out_valid=1 and out_ready=0, the output byte and its flags stay unchanged, and in_ready is 0.
- R10: While rst_n is low at a clock edge, out_valid goes to 0 and the decoder drops any partial frame. After reset the next non-zero byte is read as a code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | BYTE_W | Encoded byte |
| in_valid | input | 1 | Encoded byte present |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| out_data | output | BYTE_W | Decoded byte |
| out_valid | output | 1 | Decoded byte present |
| out_ready | input | 1 | Receiver takes the byte this cycle |
| out_last | output | 1 | Final byte of a decoded frame |
| out_user | output | 1 | Frame malformed or empty (on final byte only) |

## Verification
The assertions assume that the sender follows the valid/ready rule: a byte counts as taken only in a cycle where in_valid and in_ready are both high. They also assume that the receiver's out_ready may change freely from cycle to cycle. The stimulus changes in_valid and in_data only half a cycle after an edge and keeps them until in_ready has been seen high. It inserts a repeating stall on out_ready so that the held-output case comes up, and it keeps in_valid low throughout any reset.

// File: rtl/cobs_dec_pkg.sv
// Shared definitions for the byte-stuffed frame decoder.
// Assumes: nothing beyond the importing modules' parameters.
package cobs_dec_pkg;

    // Position of the block walker within a frame.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // between frames, no byte of a frame seen yet
        PH_CODE  = 2'd1,   // inside a frame, next byte is a code
        PH_BLOCK = 2'd2    // inside a block, data bytes still expected
    } phase_t;

endpackage

// File: rtl/cobs_block_tracker.sv
// Walks encoded frames block by block. For each accepted byte it reports
// at most one decoded byte, or, for a delimiter that closes a frame, a
// frame-end event with a truncation flag.
// Assumes: acc is high only in cycles where a byte is really taken.
module cobs_block_tracker
    import cobs_dec_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              dec_valid,
    output logic [BYTE_W-1:0] dec_data,
    output logic              frame_end,
    output logic              frame_err
);

    localparam logic [BYTE_W-1:0] ONE = BYTE_W'(1);

    phase_t            phase_q, phase_n;
    logic [BYTE_W-1:0] remain_q, remain_n;
    logic              big_q, big_n;
    logic              zero_due_q, zero_due_n;
    logic              is_delim;

    assign is_delim = (byte_in == '0);

    // Decide the decoded byte and the next walker state for this byte.
    always_comb begin
        phase_n    = phase_q;
        remain_n   = remain_q;
        big_n      = big_q;
        zero_due_n = zero_due_q;
        dec_valid  = 1'b0;
        dec_data   = byte_in;
        frame_end  = 1'b0;
        frame_err  = 1'b0;
        if (acc) begin
            if (is_delim) begin
                frame_end  = (phase_q != PH_IDLE);
                frame_err  = (phase_q == PH_BLOCK);
                phase_n    = PH_IDLE;
                remain_n   = '0;
                zero_due_n = 1'b0;
            end else begin
                case (phase_q)
                    PH_BLOCK: begin
                        dec_valid = 1'b1;
                        dec_data  = byte_in;
                        remain_n  = remain_q - ONE;
                        if (remain_q == ONE) begin
                            phase_n    = PH_CODE;
                            zero_due_n = !big_q;
                        end
                    end
                    default: begin
                        dec_valid  = zero_due_q;
                        dec_data   = '0;
                        big_n      = &byte_in;
                        remain_n   = byte_in - ONE;
                        zero_due_n = 1'b0;
                        if (byte_in == ONE) begin
                            phase_n    = PH_CODE;
                            zero_due_n = 1'b1;
                        end else begin
                            phase_n    = PH_BLOCK;
                        end
                    end
                endcase
            end
        end
    end

    // Register the walker state; reset returns it to awaiting a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            remain_q   <= '0;
            big_q      <= 1'b0;
            zero_due_q <= 1'b0;
        end else begin
            phase_q    <= phase_n;
            remain_q   <= remain_n;
            big_q      <= big_n;
            zero_due_q <= zero_due_n;
        end
    end

    AST_DELIM_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_delim) |=> (phase_q == PH_IDLE && !zero_due_q)) else $error("delimiter left frame open"); // R5

    AST_BLOCK_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BLOCK) |-> (remain_q != '0)) else $error("block phase with no bytes due"); // R1

    AST_MAX_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !is_delim && phase_q == PH_BLOCK && big_q && remain_q == ONE) |=> !zero_due_q) else $error("zero pending after max code"); // R3

endmodule

// File: rtl/cobs_holdback.sv
// Keeps the most recent decoded byte back by one so that the frame's
// final byte can be marked once the delimiter arrives. Produces at most
// one output beat per accepted input byte.
// Assumes: dec_valid and frame_end are never high together.
module cobs_holdback #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              dec_valid,
    input  logic [BYTE_W-1:0] dec_data,
    input  logic              frame_end,
    input  logic              frame_err,
    output logic              emit,
    output logic [BYTE_W-1:0] emit_data,
    output logic              emit_last,
    output logic              emit_user
);

    logic              held_valid_q;
    logic [BYTE_W-1:0] held_data_q;

    // Release the held byte when a newer one arrives or the frame closes.
    always_comb begin
        emit      = acc && ((dec_valid && held_valid_q) || frame_end);
        emit_last = frame_end;
        emit_user = frame_end && (frame_err || !held_valid_q);
        emit_data = held_valid_q ? held_data_q : '0;
    end

    // Capture each decoded byte; empty the slot when a frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_valid_q <= 1'b0;
            held_data_q  <= '0;
        end else if (acc) begin
            if (frame_end) begin
                held_valid_q <= 1'b0;
            end else if (dec_valid) begin
                held_valid_q <= 1'b1;
                held_data_q  <= dec_data;
            end
        end
    end

    AST_FRAME_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && frame_end) |=> !held_valid_q) else $error("byte kept across frame end"); // R4

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && frame_end)) else $error("decode and frame end together"); // R5

endmodule

// File: rtl/cobs_out_stage.sv
// Single output register with valid/ready. It can take a new beat when
// empty or when the current one leaves in the same cycle.
// Assumes: load is raised only while can_take is high.
module cobs_out_stage #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              ld_last,
    input  logic              ld_user,
    input  logic              m_ready,
    output logic              can_take,
    output logic              m_valid,
    output logic [BYTE_W-1:0] m_data,
    output logic              m_last,
    output logic              m_user
);

    assign can_take = !m_valid || m_ready;

    // Hold the beat until taken; replace it when a new one is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_data  <= '0;
            m_last  <= 1'b0;
            m_user  <= 1'b0;
        end else if (load) begin
            m_valid <= 1'b1;
            m_data  <= ld_data;
            m_last  <= ld_last;
            m_user  <= ld_user;
        end else if (m_ready) begin
            m_valid <= 1'b0;
        end
    end

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last) && $stable(m_user))) else $error("output changed while stalled"); // R9

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> can_take) else $error("beat loaded over a stalled one"); // R9

endmodule

// File: rtl/cobs_frame_decoder.sv
// Top level: decodes zero-delimited, byte-stuffed frames into plain byte
// frames with last and error flags on the final byte.
// Assumes: the sender keeps in_data steady until in_ready is seen high.
module cobs_frame_decoder #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_last,
    output logic              out_user
);

    logic              acc;
    logic              dec_valid;
    logic [BYTE_W-1:0] dec_data;
    logic              frame_end;
    logic              frame_err;
    logic              emit;
    logic [BYTE_W-1:0] emit_data;
    logic              emit_last;
    logic              emit_user;
    logic              can_take;

    // A byte is taken only when the output register has room for its result.
    assign in_ready = can_take;
    assign acc      = in_valid && can_take;

    cobs_block_tracker #(.BYTE_W(BYTE_W)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .byte_in   (in_data),
        .dec_valid (dec_valid),
        .dec_data  (dec_data),
        .frame_end (frame_end),
        .frame_err (frame_err)
    );

    cobs_holdback #(.BYTE_W(BYTE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .dec_valid (dec_valid),
        .dec_data  (dec_data),
        .frame_end (frame_end),
        .frame_err (frame_err),
        .emit      (emit),
        .emit_data (emit_data),
        .emit_last (emit_last),
        .emit_user (emit_user)
    );

    cobs_out_stage #(.BYTE_W(BYTE_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (emit),
        .ld_data  (emit_data),
        .ld_last  (emit_last),
        .ld_user  (emit_user),
        .m_ready  (out_ready),
        .can_take (can_take),
        .m_valid  (out_valid),
        .m_data   (out_data),
        .m_last   (out_last),
        .m_user   (out_user)
    );

    AST_USER_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !out_user) else $error("error flag away from frame end"); // R6

    AST_BLOCKED_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready) else $error("input taken while output stalled"); // R9

endmodule

// File: tb/cobs_frame_decoder_test.sv
module cobs_frame_decoder_test;

    typedef logic [7:0] byteq_t[$];
    typedef logic [9:0] beatq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       out_last;
    logic       out_user;

    int   n_checks = 0;
    int   n_errors = 0;
    int   ncyc = 0;
    int   stall_viol = 0;
    bit   stall_en = 1'b0;
    bit   finished = 1'b0;
    bit   prev_stalled = 1'b0;
    logic [10:0] prev_beat = '0;
    logic [9:0]  got[$];

    cobs_frame_decoder #(.BYTE_W(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_last(out_last), .out_user(out_user)
    );

    always #10 clk = ~clk;

    // Receiver: choose out_ready, then record the handshake due at the next edge.
    always @(negedge clk) begin
        out_ready = stall_en ? ((ncyc % 4) != 3) : 1'b1;
        ncyc++;
        if (prev_stalled && rst_n && ({out_valid, out_user, out_last, out_data} != prev_beat))
            stall_viol++;
        if (rst_n && out_valid && out_ready)
            got.push_back({out_user, out_last, out_data});
        prev_stalled = rst_n && out_valid && !out_ready;
        prev_beat    = {out_valid, out_user, out_last, out_data};
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the byte was taken.
    task automatic send_byte(input logic [7:0] b);
        bit ok;
        in_valid = 1'b1;
        in_data  = b;
        do begin
            #1 ok = in_ready;
            @(negedge clk);
        end while (!ok);
        in_valid = 1'b0;
    endtask

    // Expected decode of one whole frame, taken from the requirements.
    function automatic beatq_t model(input byteq_t enc);
        beatq_t     res;
        logic [7:0] plain[$];
        int         i = 0;
        bit         bad = 1'b0;
        while (i < enc.size()) begin
            int code = enc[i];
            i++;
            for (int k = 1; k < code; k++) begin
                if (i >= enc.size()) begin
                    bad = 1'b1;
                    break;
                end
                plain.push_back(enc[i]);
                i++;
            end
            if (code != 255 && i < enc.size())
                plain.push_back(8'h00);
        end
        if (plain.size() == 0) begin
            res.push_back({1'b1, 1'b1, 8'h00});
        end else begin
            for (int k = 0; k < plain.size(); k++) begin
                bit fin = (k == plain.size() - 1);
                res.push_back({fin && bad, fin, plain[k]});
            end
        end
        return res;
    endfunction

    task automatic run_frame(input byteq_t enc, input string req);
        beatq_t exp;
        int     bad_idx = -1;
        got.delete();
        foreach (enc[k]) send_byte(enc[k]);
        send_byte(8'h00);
        repeat (30) @(negedge clk);
        exp = model(enc);
        check(got.size() == exp.size(), req, "beat count", got.size(), exp.size());
        for (int k = 0; k < exp.size() && k < got.size(); k++)
            if (bad_idx < 0 && got[k] != exp[k]) bad_idx = k;
        check(bad_idx < 0, req, "beat {user,last,data}",
              bad_idx < 0 ? 0 : got[bad_idx], bad_idx < 0 ? 0 : exp[bad_idx]);
    endtask

    task automatic do_reset;
        in_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        do_reset();
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_blocks;
        run_frame('{8'h03, 8'h11, 8'h22, 8'h02, 8'h33}, "R1 R2 R5");
        run_frame('{8'h01, 8'h01, 8'h02, 8'h5A}, "R2 zero run");
    endtask

    task automatic t_final_block;
        run_frame('{8'h03, 8'h11, 8'h22, 8'h01}, "R4 code-1 tail");
        run_frame('{8'h02, 8'h44}, "R4 single block");
    endtask

    task automatic t_max_code;
        byteq_t enc;
        enc.push_back(8'hFF);
        for (int k = 1; k <= 254; k++) enc.push_back(8'(k));
        enc.push_back(8'h02);
        enc.push_back(8'hAA);
        run_frame(enc, "R3 max code");
        check(got.size() > 254 && got[254][7:0] == 8'hAA, "R3", "byte after max block",
              got.size() > 254 ? got[254][7:0] : 0, 8'hAA);
    endtask

    task automatic t_truncated;
        run_frame('{8'h04, 8'h11, 8'h22}, "R6 short block");
        run_frame('{8'h02, 8'h10, 8'h03}, "R6 code then end");
    endtask

    task automatic t_empty;
        run_frame('{8'h01}, "R7 empty frame");
    endtask

    task automatic t_delims;
        got.delete();
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h00);
        repeat (10) @(negedge clk);
        check(got.size() == 0, "R8", "output from bare delimiters", got.size(), 0);
        run_frame('{8'h02, 8'h77}, "R8 frame after delimiters");
    endtask

    task automatic t_stall;
        stall_en = 1'b1;
        run_frame('{8'h03, 8'h11, 8'h22, 8'h02, 8'h33, 8'h04, 8'h01, 8'h02, 8'h03}, "R9 stalled");
        run_frame('{8'h05, 8'h21, 8'h22}, "R9 stalled truncated");
        stall_en = 1'b0;
        check(stall_viol == 0, "R9", "changes while stalled", stall_viol, 0);
    endtask

    task automatic t_reset_mid;
        send_byte(8'h05);
        send_byte(8'h11);
        send_byte(8'h12);
        do_reset();
        run_frame('{8'h02, 8'h66}, "R10 frame after reset");
    endtask

    initial begin
        t_reset_state();
        t_blocks();
        t_final_block();
        t_max_code();
        t_truncated();
        t_empty();
        t_delims();
        t_stall();
        t_reset_mid();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule